// File: doc/BRIEF.md
# PIO Timing Nanosecond-to-Clock Encoder

This block turns programmed-I/O timing figures for the two drives of one ATA channel into bus-clock counts. It then packs them into the bytes a disk controller's timing registers expect. Each drive supplies a present flag and three times in nanoseconds: address setup, active pulse and full cycle. The request also carries the bus frequency in MHz and a read-prefetch enable.

Every time is converted by ceiling division by 1000. A single serial restoring divider carries out the conversions one after another. A drive that is not present skips its conversions and takes minimal values. The address setup is common to both drives, so the larger of the two counts is used.

A request enters on a valid/ready handshake and the result leaves on another. `req_ready` is high only when the sequencer is idle and no result is waiting to be taken, or the waiting result is taken in that same cycle. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. Once `res_valid` rises, it and the three result bytes hold unchanged until a cycle with `res_ready` high takes them. This lets the consumer stall for as long as it needs.

Top module: `pio_timing_encoder`

## Requirements
- R1: Each time t in ns converts to clocks as floor((t × f + 999) / 1000), where f is `bus_mhz`. This is the ceiling of t × f / 1000.
- R2: Recovery time in ns is cycle minus setup minus active for that drive. When that difference is zero or negative, 0 ns is converted, which R5 then raises to 2 clocks.
- R3: The address setup count of each drive is clamped to the range 1 to 4 clocks.
- R4: The data (active) count is clamped to the range 1 to 16 clocks.
- R5: The recovery count is clamped to the range 2 to 17 clocks.
- R6: A drive whose bit in `drv_present` is 0 uses address 1, data 1 and recovery 2 clocks, whatever its time inputs hold.
- R7: The address setup count placed in the shared byte is the larger of the two drives' clamped counts.
- R8: `res_cyc0` carries drive 0 and `res_cyc1` carries drive 1. In each, bits 7:4 hold data − 1 and bits 3:0 hold recovery − 2.
- R9: `res_misc` bit 6 is `prefetch_en` as captured with the request, and bits 5:4 hold address − 1. Bits 2:1 hold the ready-wait count − 2, with that count fixed at 2, so they read 00. Bits 7, 3 and 0 are 0.
- R10: `req_ready` is high only when no conversion is running and no result is pending, unless the pending result is taken in that cycle. It falls in the cycle after an accept.
- R11: While `res_valid` is high and `res_ready` is low, `res_valid` and all three result bytes stay unchanged on the next cycle.
- R12: When a pending result is taken, a waiting request is accepted at the same clock edge.
- R13: After reset, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mhz | input | MHZ_W | Bus frequency in MHz |
| prefetch_en | input | 1 | Read-prefetch enable for the shared byte |
| drv_present | input | 2 | Per-drive present flag (bit 0 = drive 0) |
| setup_ns | input | 2×NS_W | Address setup time per drive, ns |
| active_ns | input | 2×NS_W | Active pulse time per drive, ns |
| cycle_ns | input | 2×NS_W | Full cycle time per drive, ns |
| req_valid | input | 1 | Request inputs are valid |
| req_ready | output | 1 | Block can accept a request |
| res_cyc0 | output | 8 | Cycle byte, drive 0 |
| res_cyc1 | output | 8 | Cycle byte, drive 1 |
| res_misc | output | 8 | Shared byte: prefetch, address setup, ready-wait |
| res_valid | output | 1 | Result bytes valid |
| res_ready | input | 1 | Consumer takes the result |

## Verification
Two things can happen at one clock edge: the consumer takes a finished result, and a new request is accepted. The bench provokes this by holding `res_ready` low after a result appears, with a second request already waiting on `req_valid`. It then raises `res_ready`. During the stall, the result bytes must stay frozen and `req_ready` must stay low. At release, the bench counts a cycle in which both handshakes complete together. The scoreboard then requires the old result to pop first and the new request's result to follow, each matching values computed from the conversion rules.

// File: rtl/pio_enc_pkg.sv
package pio_enc_pkg;

  localparam int CLK_W     = 8;
  localparam int DIVISOR   = 1000;
  localparam int ROUND_ADD = DIVISOR - 1;

  localparam int ADDR_MIN  = 1;
  localparam int ADDR_MAX  = 4;
  localparam int DATA_MIN  = 1;
  localparam int DATA_MAX  = 16;
  localparam int REC_MIN   = 2;
  localparam int REC_MAX   = 17;
  localparam int DRDY_CLKS = 2;
  localparam int DRDY_MIN  = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_DATA = 2'd1,
    FLD_REC  = 2'd2
  } fld_t;

endpackage

// File: rtl/pio_ns2clk.sv
module pio_ns2clk
  import pio_enc_pkg::*;
#(
  parameter int NS_W  = 10,
  parameter int MHZ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NS_W-1:0]  ns,
  input  logic [MHZ_W-1:0] mhz,
  output logic             done,
  output logic [CLK_W-1:0] clks
);

  localparam int NUM_W = NS_W + MHZ_W + 1;
  localparam int REM_W = $clog2(DIVISOR);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] quo;
  logic [REM_W-1:0] rem;
  logic [REM_W:0]   trial;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign num   = NUM_W'(ns) * NUM_W'(mhz) + NUM_W'(ROUND_ADD);
  assign trial = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo  <= '0;
      rem  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      quo  <= num;
      rem  <= '0;
      cnt  <= CNT_W'(NUM_W);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      if (trial >= (REM_W+1)'(DIVISOR)) begin
        rem <= REM_W'(trial - (REM_W+1)'(DIVISOR));
        quo <= {quo[NUM_W-2:0], 1'b1};
      end else begin
        rem <= trial[REM_W-1:0];
        quo <= {quo[NUM_W-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // saturate quotients that do not fit; the clamp stage caps them anyway
  assign clks = (|quo[NUM_W-1:CLK_W]) ? '1 : quo[CLK_W-1:0];

endmodule

// File: rtl/pio_field_pack.sv
module pio_field_pack
  import pio_enc_pkg::*;
(
  input  logic [1:0][2:0][CLK_W-1:0] raw,
  input  logic                       prefetch,
  output logic [1:0][7:0]            cyc,
  output logic [7:0]                 misc
);

  function automatic logic [CLK_W-1:0] clampv(input logic [CLK_W-1:0] v,
                                              input logic [CLK_W-1:0] lo,
                                              input logic [CLK_W-1:0] hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

  logic [1:0][CLK_W-1:0] addr_c;
  logic [CLK_W-1:0]      addr_x;

  for (genvar d = 0; d < 2; d++) begin : g_drv
    logic [CLK_W-1:0] data_c;
    logic [CLK_W-1:0] rec_c;
    always_comb begin
      addr_c[d] = clampv(raw[d][FLD_ADDR], CLK_W'(ADDR_MIN), CLK_W'(ADDR_MAX));
      data_c    = clampv(raw[d][FLD_DATA], CLK_W'(DATA_MIN), CLK_W'(DATA_MAX));
      rec_c     = clampv(raw[d][FLD_REC],  CLK_W'(REC_MIN),  CLK_W'(REC_MAX));
      cyc[d]    = {4'(data_c - CLK_W'(DATA_MIN)), 4'(rec_c - CLK_W'(REC_MIN))};
    end
  end

  assign addr_x = (addr_c[0] > addr_c[1]) ? addr_c[0] : addr_c[1];
  assign misc   = {1'b0, prefetch, 2'(addr_x - CLK_W'(ADDR_MIN)), 1'b0,
                   2'(DRDY_CLKS - DRDY_MIN), 1'b0};

endmodule

// File: rtl/pio_timing_encoder.sv
module pio_timing_encoder
  import pio_enc_pkg::*;
#(
  parameter int NS_W  = 10,
  parameter int MHZ_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MHZ_W-1:0]     bus_mhz,
  input  logic                 prefetch_en,
  input  logic [1:0]           drv_present,
  input  logic [1:0][NS_W-1:0] setup_ns,
  input  logic [1:0][NS_W-1:0] active_ns,
  input  logic [1:0][NS_W-1:0] cycle_ns,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic [7:0]           res_cyc0,
  output logic [7:0]           res_cyc1,
  output logic [7:0]           res_misc,
  output logic                 res_valid,
  input  logic                 res_ready
);

  seq_st_t               st;
  fld_t                  fld;
  logic                  drv;
  logic [MHZ_W-1:0]      l_mhz;
  logic                  l_pf;
  logic [1:0]            l_pres;
  logic [1:0][NS_W-1:0]  l_setup, l_act, l_cyc;
  logic [1:0][NS_W-1:0]  rec_ns;
  logic [1:0][2:0][CLK_W-1:0] raw;

  logic             accept, last, div_start, div_done;
  logic [NS_W-1:0]  sel_ns;
  logic [CLK_W-1:0] div_clks, dflt;
  logic [1:0][7:0]  pk_cyc;
  logic [7:0]       pk_misc;

  for (genvar g = 0; g < 2; g++) begin : g_rec
    logic signed [NS_W+1:0] diff;
    assign diff = $signed({2'b00, l_cyc[g]}) - $signed({2'b00, l_setup[g]})
                - $signed({2'b00, l_act[g]});
    assign rec_ns[g] = (diff > 0) ? diff[NS_W-1:0] : '0;
  end

  assign req_ready = (st == ST_IDLE) && (!res_valid || res_ready);
  assign accept    = req_valid && req_ready;
  assign last      = drv && (fld == FLD_REC);
  assign div_start = (st == ST_ISSUE) && l_pres[drv];
  assign dflt      = (fld == FLD_REC) ? CLK_W'(REC_MIN) : CLK_W'(1);

  always_comb begin
    case (fld)
      FLD_ADDR: sel_ns = l_setup[drv];
      FLD_DATA: sel_ns = l_act[drv];
      default:  sel_ns = rec_ns[drv];
    endcase
  end

  pio_ns2clk #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .ns    (sel_ns),
    .mhz   (l_mhz),
    .done  (div_done),
    .clks  (div_clks)
  );

  pio_field_pack u_pack (
    .raw      (raw),
    .prefetch (l_pf),
    .cyc      (pk_cyc),
    .misc     (pk_misc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      fld       <= FLD_ADDR;
      drv       <= 1'b0;
      l_mhz     <= '0;
      l_pf      <= 1'b0;
      l_pres    <= '0;
      l_setup   <= '0;
      l_act     <= '0;
      l_cyc     <= '0;
      raw       <= '0;
      res_cyc0  <= '0;
      res_cyc1  <= '0;
      res_misc  <= '0;
      res_valid <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          l_mhz   <= bus_mhz;
          l_pf    <= prefetch_en;
          l_pres  <= drv_present;
          l_setup <= setup_ns;
          l_act   <= active_ns;
          l_cyc   <= cycle_ns;
          drv     <= 1'b0;
          fld     <= FLD_ADDR;
          st      <= ST_ISSUE;
        end
        ST_ISSUE, ST_WAIT: begin
          if ((st == ST_ISSUE && !l_pres[drv]) || (st == ST_WAIT && div_done)) begin
            raw[drv][fld] <= (st == ST_ISSUE) ? dflt : div_clks;
            if (last) begin
              st <= ST_FINISH;
            end else begin
              st <= ST_ISSUE;
              if (fld == FLD_REC) begin
                fld <= FLD_ADDR;
                drv <= 1'b1;
              end else begin
                fld <= fld_t'(fld + 2'd1);
              end
            end
          end else if (st == ST_ISSUE) begin
            st <= ST_WAIT;
          end
        end
        default: begin
          res_cyc0  <= pk_cyc[0];
          res_cyc1  <= pk_cyc[1];
          res_misc  <= pk_misc;
          res_valid <= 1'b1;
          st        <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/pio_timing_encoder_chk.sv
module pio_timing_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] res_cyc0,
  input logic [7:0] res_cyc1,
  input logic [7:0] res_misc,
  input logic       res_valid,
  input logic       res_ready
);

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_cyc0) &&
                                   $stable(res_cyc1) && $stable(res_misc)));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  no_ready_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);

  // R9
  misc_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_misc[7] == 1'b0 && res_misc[3:0] == 4'h0));

  // R11
  valid_drops_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> $past(res_ready));

endmodule

bind pio_timing_encoder pio_timing_encoder_chk u_chk (.*);

// File: tb/sim_pio_timing_encoder.sv
module sim_pio_timing_encoder;

  localparam int NS_W  = 10;
  localparam int MHZ_W = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [MHZ_W-1:0]     bus_mhz = '0;
  logic                 prefetch_en = 1'b0;
  logic [1:0]           drv_present = '0;
  logic [1:0][NS_W-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [7:0]           res_cyc0, res_cyc1, res_misc;
  logic                 res_valid;
  logic                 res_ready = 1'b1;

  always #5 clk = ~clk;

  pio_timing_encoder #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u0 (.*);

  typedef struct {
    logic [7:0] c0, c1, m;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0, n_fail = 0, n_overlap = 0;
  bit   stall = 1'b0;
  bit   finished = 1'b0;

  function automatic int to_clk(int t, int f);
    return (t * f + 999) / 1000;
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic send(bit p0, int s0, int a0, int c0, bit p1, int s1, int a1,
                      int c1, int mhz, bit pf, string tag);
    int pr[2], su[2], ac[2], cy[2], ad[2], dt[2], rc[2], ax;
    exp_t e;
    pr = '{int'(p0), int'(p1)}; su = '{s0, s1}; ac = '{a0, a1}; cy = '{c0, c1};
    for (int d = 0; d < 2; d++) begin
      if (pr[d] != 0) begin
        int r;
        r     = cy[d] - su[d] - ac[d];
        ad[d] = clampi(to_clk(su[d], mhz), 1, 4);
        dt[d] = clampi(to_clk(ac[d], mhz), 1, 16);
        rc[d] = clampi(to_clk((r > 0) ? r : 0, mhz), 2, 17);
      end else begin
        ad[d] = 1; dt[d] = 1; rc[d] = 2;
      end
    end
    ax    = (ad[0] > ad[1]) ? ad[0] : ad[1];
    e.c0  = 8'(((dt[0] - 1) << 4) | (rc[0] - 2));
    e.c1  = 8'(((dt[1] - 1) << 4) | (rc[1] - 2));
    e.m   = 8'((int'(pf) << 6) | ((ax - 1) << 4));
    e.tag = tag;
    @(negedge clk);
    drv_present = {p1, p0};
    setup_ns    = {NS_W'(s1), NS_W'(s0)};
    active_ns   = {NS_W'(a1), NS_W'(a0)};
    cycle_ns    = {NS_W'(c1), NS_W'(c0)};
    bus_mhz     = MHZ_W'(mhz);
    prefetch_en = pf;
    req_valid   = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // result monitor: pops expected items as results are taken
  initial begin
    logic [7:0] pc0, pc1, pm;
    bit         pstall = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pstall) begin
          // R11: stalled result stays frozen
          check(res_valid && res_cyc0 == pc0 && res_cyc1 == pc1 && res_misc == pm,
                "R11 hold", {res_cyc0, res_cyc1, res_misc}, {pc0, pc1, pm});
        end
        pstall = res_valid && !res_ready;
        pc0 = res_cyc0; pc1 = res_cyc1; pm = res_misc;
        if (res_valid && !res_ready)
          check(!req_ready, "R10 ready low while pending", int'(req_ready), 0);
        if (res_valid && res_ready) begin
          if (req_valid && req_ready) n_overlap++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected result", int'(res_cyc0), 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(res_cyc0 == e.c0, {e.tag, " R8 cyc0"}, int'(res_cyc0), int'(e.c0));
            check(res_cyc1 == e.c1, {e.tag, " R8 cyc1"}, int'(res_cyc1), int'(e.c1));
            check(res_misc == e.m,  {e.tag, " R9 misc"}, int'(res_misc), int'(e.m));
          end
        end
      end
    end
  end

  // consumer ready pattern, changed away from the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #2 res_ready = !stall;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13
    check(res_valid == 1'b0, "R13 res_valid after reset", int'(res_valid), 0);
    check(req_ready == 1'b1, "R13 req_ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(1, 70, 165, 600, 1, 70, 165, 600, 33, 1'b0, "R1 R2 slow mode");
    send(1, 30, 80, 180, 1, 25, 70, 120, 33, 1'b1, "R1 fast mode");
    send(1, 70, 165, 600, 0, 900, 900, 100, 25, 1'b0, "R6 drive1 absent");
    send(0, 900, 900, 100, 1, 30, 80, 180, 40, 1'b1, "R6 drive0 absent");
    send(0, 500, 500, 500, 0, 1, 1, 1, 255, 1'b0, "R6 both absent");
    send(1, 500, 1000, 1023, 1, 500, 1000, 1023, 255, 1'b0, "R2 R3 R4 high clamp");
    send(1, 0, 0, 1023, 1, 0, 0, 1023, 255, 1'b1, "R5 low addr data, high rec");
    send(1, 20, 100, 300, 1, 100, 100, 300, 33, 1'b1, "R7 max setup drive1");
    send(1, 110, 100, 400, 1, 15, 100, 400, 20, 1'b0, "R7 max setup drive0");
    send(1, 100, 200, 300, 1, 50, 60, 110, 50, 1'b0, "R2 zero recovery");

    for (int i = 0; i < 16; i++)
      send(1'($urandom_range(0, 1)), $urandom_range(0, 300), $urandom_range(0, 600),
           $urandom_range(0, 1023), 1'($urandom_range(0, 1)), $urandom_range(0, 300),
           $urandom_range(0, 600), $urandom_range(0, 1023), $urandom_range(1, 255),
           1'($urandom_range(0, 1)), "R1 random");

    // R12: back-pressure with a second request waiting
    while (exp_q.size() != 0) @(negedge clk);
    stall = 1'b1;
    send(1, 70, 165, 600, 1, 30, 80, 180, 33, 1'b1, "R11 stalled first");
    fork
      send(1, 25, 70, 120, 0, 0, 0, 0, 66, 1'b0, "R12 queued second");
      begin
        while (!res_valid) @(negedge clk);
        repeat (6) @(negedge clk);
        check(!req_ready, "R10 ready low during stall", int'(req_ready), 0);
        stall = 1'b0;
      end
    join
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(n_overlap > 0, "R12 take and accept same cycle", n_overlap, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule